// File: doc/BRIEF.md
# Dual-Channel Hiccup Fault Sequencer

This block is the digital supervisor for a pair of linear regulator channels. It watches a power-good signal (the release of the power-on reset), one active-low shutdown input per channel, and one undervoltage comparator flag per channel, which is raised while that channel's output sits below 80% of its nominal level. For each channel it drives an enable for the control amplifier and reports a two-bit status.

After power-good rises, and again whenever either channel is switched on, a single shared start-up window runs. During it both channels are enabled and undervoltage flags are ignored, so outputs can ramp without tripping protection. Once the window has closed, an undervoltage flag that persists through a glitch filter puts that channel into hiccup mode. In that mode the enable is pulsed: a short on-window, then an off-window forty times longer by default. The channel returns to regulation only when its flag is seen low during an on-window. All durations are parameters in clock cycles. The shutdown, undervoltage and power-good inputs are brought through two-flop synchronizers.

Top module: `dual_hiccup_seq`

## Requirements
- R1: A channel's `amp_en` bit is 0 whenever its `shut_n` bit or `pwr_good` is 0. A falling `shut_n` drops `amp_en` on the third rising clock edge after the change. The status of a channel that is shut down is 2'b00.
- R2: A rising `pwr_good` starts a shared hold-off window of `HOLDOFF_CYC` cycles. While it runs, every enabled channel reports status 2'b01 and holds `amp_en` at 1, and `uv_low` has no effect.
- R3: A rising edge on either `shut_n` bit restarts the hold-off window. Both channels then report 2'b01, including a channel that was already regulating.
- R4: After hold-off, a channel in regulation (status 2'b10) whose filtered `uv_low` is active enters hiccup (status 2'b11). It starts with an off-window, with `amp_en` at 0.
- R5: In hiccup mode with the fault still present, `amp_en` is high for exactly `ON_CYC` cycles and low for exactly `OFF_CYC` cycles, repeating.
- R6: A channel leaves hiccup only when its synchronized `uv_low` is 0 during an on-window. It then returns to status 2'b10 with `amp_en` held at 1.
- R7: A fault that clears during an off-window does not end that off-window. `amp_en` stays 0 and the status stays 2'b11 until the off-window has run its full length.
- R8: A `uv_low` pulse counts only after it has been high for `GLITCH_CYC` consecutive synchronized cycles. A pulse of `GLITCH_CYC-1` cycles leaves the channel in status 2'b10.
- R9: A synchronous active-high `rst` forces both channels to status 2'b00 (the encodings are 00 off, 01 hold-off, 10 regulating, 11 hiccup) with `amp_en` at 0, and clears all counters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | Supply above reset threshold |
| shut_n | input | 2 | Per-channel active-low shutdown, bit 0 is channel 0 |
| uv_low | input | 2 | Per-channel output-below-80% flag |
| amp_en | output | 2 | Per-channel amplifier enable |
| ch0_state | output | 2 | Channel 0 status |
| ch1_state | output | 2 | Channel 1 status |

## Verification
The assertions work on the synchronized copies of the inputs. They assume that every input, once changed, is treated as a clean level, so they make no claim about the two cycles of synchronizer delay. They also assume that `pwr_good` and `shut_n` change far less often than the hold-off window runs, so a channel is not toggled again before it has settled. The stimulus changes inputs only on falling clock edges and holds each level for at least several cycles, apart from the intended short undervoltage pulses. It always lets a window expire before it checks the state that follows.

// File: rtl/hicc_pkg.sv
package hicc_pkg;

    localparam int NUM_CH = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_HOLD  = 2'b01,
        ST_REG   = 2'b10,
        ST_PULSE = 2'b11
    } chan_st_e;

    function automatic int cnt_w(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/hicc_sync.sv
module hicc_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/hicc_holdoff.sv
module hicc_holdoff
    import hicc_pkg::*;
#(
    parameter int HOLD_CYC = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pg,
    input  logic [NUM_CH-1:0] en,
    output logic              busy
);
    localparam int CW = cnt_w(HOLD_CYC);

    logic              pg_q;
    logic [NUM_CH-1:0] en_q;
    logic [CW-1:0]     cnt;
    logic              restart;

    assign restart = (pg & ~pg_q) | (|(en & ~en_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            pg_q <= 1'b0;
            en_q <= '0;
            cnt  <= '0;
            busy <= 1'b0;
        end else begin
            pg_q <= pg;
            en_q <= en;
            if (!pg) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else if (restart) begin
                busy <= 1'b1;
                cnt  <= '0;
            end else if (busy) begin
                if (cnt == CW'(HOLD_CYC - 1)) begin
                    busy <= 1'b0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/hicc_chan.sv
module hicc_chan
    import hicc_pkg::*;
#(
    parameter int GLITCH_CYC = 4,
    parameter int ON_CYC     = 4,
    parameter int OFF_CYC    = 160
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     pg,
    input  logic     en,
    input  logic     uv,
    input  logic     hold,
    output logic     amp_en,
    output chan_st_e state
);
    localparam int GW   = cnt_w(GLITCH_CYC);
    localparam int PMAX = (ON_CYC > OFF_CYC) ? ON_CYC : OFF_CYC;
    localparam int PW   = cnt_w(PMAX);

    logic [GW-1:0] glt_cnt;
    logic          uv_q;
    chan_st_e      st_n;
    logic          ph_on, ph_on_n;
    logic [PW-1:0] ph_cnt, ph_cnt_n;

    // glitch filter: saturating count of consecutive flag cycles
    assign uv_q = (glt_cnt == GW'(GLITCH_CYC));

    always_ff @(posedge clk) begin
        if (rst || !uv) begin
            glt_cnt <= '0;
        end else if (!uv_q) begin
            glt_cnt <= glt_cnt + 1'b1;
        end
    end

    always_comb begin
        st_n     = state;
        ph_on_n  = ph_on;
        ph_cnt_n = ph_cnt;
        if (!pg || !en) begin
            st_n = ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: st_n = ST_HOLD;
                ST_HOLD: if (!hold) st_n = ST_REG;
                ST_REG: begin
                    if (hold) begin
                        st_n = ST_HOLD;
                    end else if (uv_q) begin
                        st_n     = ST_PULSE;
                        ph_on_n  = 1'b0;
                        ph_cnt_n = '0;
                    end
                end
                ST_PULSE: begin
                    if (hold) begin
                        st_n = ST_HOLD;
                    end else if (ph_on && !uv) begin
                        st_n = ST_REG;
                    end else if (ph_on) begin
                        if (ph_cnt == PW'(ON_CYC - 1)) begin
                            ph_on_n  = 1'b0;
                            ph_cnt_n = '0;
                        end else begin
                            ph_cnt_n = ph_cnt + 1'b1;
                        end
                    end else begin
                        if (ph_cnt == PW'(OFF_CYC - 1)) begin
                            ph_on_n  = 1'b1;
                            ph_cnt_n = '0;
                        end else begin
                            ph_cnt_n = ph_cnt + 1'b1;
                        end
                    end
                end
                default: st_n = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            ph_on  <= 1'b0;
            ph_cnt <= '0;
        end else begin
            state  <= st_n;
            ph_on  <= ph_on_n;
            ph_cnt <= ph_cnt_n;
        end
    end

    assign amp_en = (state == ST_HOLD) || (state == ST_REG) ||
                    ((state == ST_PULSE) && ph_on);
endmodule

// File: rtl/dual_hiccup_seq.sv
module dual_hiccup_seq
    import hicc_pkg::*;
#(
    parameter int HOLDOFF_CYC = 6_000_000,
    parameter int ON_CYC      = 1000,
    parameter int OFF_CYC     = 40 * ON_CYC,
    parameter int GLITCH_CYC  = 100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pwr_good,
    input  logic [1:0] shut_n,
    input  logic [1:0] uv_low,
    output logic [1:0] amp_en,
    output logic [1:0] ch0_state,
    output logic [1:0] ch1_state
);
    localparam int SW = 1 + 2 * NUM_CH;

    logic [SW-1:0]     sync_q;
    logic              pg_s;
    logic [NUM_CH-1:0] en_s;
    logic [NUM_CH-1:0] uv_s;
    logic              hold_busy;
    chan_st_e          st [NUM_CH];
    logic [3:0]        st_all;

    hicc_sync #(.W(SW)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({uv_low, shut_n, pwr_good}),
        .q   (sync_q)
    );

    assign pg_s = sync_q[0];
    assign en_s = sync_q[NUM_CH:1];
    assign uv_s = sync_q[2*NUM_CH:NUM_CH+1];

    hicc_holdoff #(.HOLD_CYC(HOLDOFF_CYC)) u_hold (
        .clk  (clk),
        .rst  (rst),
        .pg   (pg_s),
        .en   (en_s),
        .busy (hold_busy)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        hicc_chan #(
            .GLITCH_CYC (GLITCH_CYC),
            .ON_CYC     (ON_CYC),
            .OFF_CYC    (OFF_CYC)
        ) u_chan (
            .clk    (clk),
            .rst    (rst),
            .pg     (pg_s),
            .en     (en_s[i]),
            .uv     (uv_s[i]),
            .hold   (hold_busy),
            .amp_en (amp_en[i]),
            .state  (st[i])
        );
    end

    assign ch0_state = st[0];
    assign ch1_state = st[1];
    assign st_all    = {ch1_state, ch0_state};
endmodule

// File: rtl/hicc_checker.sv
module hicc_checker (
    input logic       clk,
    input logic       rst,
    input logic       pg_s,
    input logic [1:0] en_s,
    input logic [1:0] uv_s,
    input logic       hold,
    input logic [1:0] amp_en,
    input logic [3:0] st_all
);
    for (genvar i = 0; i < 2; i++) begin : g_chk
        // R1: shutdown or missing power-good turns the enable off
        assert_off_when_down_R1: assert property (@(posedge clk) disable iff (rst)
            (!pg_s || !en_s[i]) |=> !amp_en[i]);

        // R2: while hold-off runs, an enabled channel is in hold-off
        assert_hold_state_R2: assert property (@(posedge clk) disable iff (rst)
            (hold && pg_s && en_s[i]) |=> (st_all[2*i +: 2] == 2'b01));

        // R4: hiccup always opens with the enable low
        assert_hiccup_starts_off_R4: assert property (@(posedge clk) disable iff (rst)
            $rose(st_all[2*i +: 2] == 2'b11) |-> !amp_en[i]);

        // R7: no return to regulation out of an off-window
        assert_no_exit_offwin_R7: assert property (@(posedge clk) disable iff (rst)
            (st_all[2*i +: 2] == 2'b11 && !amp_en[i]) |=> (st_all[2*i +: 2] != 2'b10));

        // R8: a flag low for two samples cannot start hiccup
        assert_filter_blocks_R8: assert property (@(posedge clk) disable iff (rst)
            (st_all[2*i +: 2] == 2'b10 && !uv_s[i] && !$past(uv_s[i]))
                |=> (st_all[2*i +: 2] != 2'b11));
    end
endmodule

bind dual_hiccup_seq hicc_checker u_chk (
    .clk    (clk),
    .rst    (rst),
    .pg_s   (pg_s),
    .en_s   (en_s),
    .uv_s   (uv_s),
    .hold   (hold_busy),
    .amp_en (amp_en),
    .st_all (st_all)
);

// File: tb/dual_hiccup_seq_bench.sv
`timescale 1ns/1ps
module dual_hiccup_seq_bench;
    localparam int HOLD = 50;
    localparam int ONC  = 4;
    localparam int OFFC = 40 * ONC;
    localparam int GLT  = 5;

    logic       clk = 1'b0;
    logic       rst;
    logic       pwr_good;
    logic [1:0] shut_n;
    logic [1:0] uv_low;
    logic [1:0] amp_en;
    logic [1:0] ch0_state;
    logic [1:0] ch1_state;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    dual_hiccup_seq #(
        .HOLDOFF_CYC (HOLD),
        .ON_CYC      (ONC),
        .OFF_CYC     (OFFC),
        .GLITCH_CYC  (GLT)
    ) u_dual_hiccup_seq (
        .clk       (clk),
        .rst       (rst),
        .pwr_good  (pwr_good),
        .shut_n    (shut_n),
        .uv_low    (uv_low),
        .amp_en    (amp_en),
        .ch0_state (ch0_state),
        .ch1_state (ch1_state)
    );

    // vector: pg, shut_n, uv_low, wait, st0, st1, amp
    localparam int NV = 9;
    localparam logic [18:0] VEC [NV] = '{
        {1'b0, 2'b11, 2'b00, 8'd10, 2'b00, 2'b00, 2'b00},  // R1 no power-good
        {1'b1, 2'b11, 2'b11, 8'd20, 2'b01, 2'b01, 2'b11},  // R2 hold-off, flags ignored
        {1'b1, 2'b11, 2'b00, 8'd60, 2'b10, 2'b10, 2'b11},  // R2 window expired
        {1'b1, 2'b10, 2'b00, 8'd10, 2'b00, 2'b10, 2'b10},  // R1 ch0 shut down
        {1'b1, 2'b11, 2'b00, 8'd10, 2'b01, 2'b01, 2'b11},  // R3 shared restart
        {1'b1, 2'b11, 2'b00, 8'd60, 2'b10, 2'b10, 2'b11},  // R3 back to regulation
        {1'b1, 2'b11, 2'b01, 8'd3,  2'b10, 2'b10, 2'b11},  // R8 short glitch
        {1'b1, 2'b11, 2'b00, 8'd10, 2'b10, 2'b10, 2'b11},  // R8 glitch ignored
        {1'b1, 2'b11, 2'b01, 8'd20, 2'b11, 2'b10, 2'b10}   // R4 ch0 hiccup, off first
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_amp0(input logic lvl, input int lim, output int n);
        n = 0;
        while (amp_en[0] != lvl && n < lim) begin
            tick(1);
            n++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        int hi;
        int lo;
        rst = 1'b1;
        pwr_good = 1'b0;
        shut_n = 2'b11;
        uv_low = 2'b00;
        tick(4);
        chk("R9 reset state", {ch0_state, ch1_state, amp_en}, 6'b000000);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            pwr_good = VEC[i][18];
            shut_n   = VEC[i][17:16];
            uv_low   = VEC[i][15:14];
            tick(int'(VEC[i][13:6]));
            chk($sformatf("vector %0d R1-group", i),
                {ch0_state, ch1_state, amp_en}, int'(VEC[i][5:0]));
        end

        // R5: on and off window lengths with the fault held
        wait_amp0(1'b1, 400, n);
        hi = 0;
        while (amp_en[0] && hi < 400) begin tick(1); hi++; end
        lo = 0;
        while (!amp_en[0] && lo < 400) begin tick(1); lo++; end
        chk("R5 on-window", hi, ONC);
        chk("R5 off-window", lo, OFFC);
        chk("R5 still hiccup", ch0_state, 2'b11);

        // R7: fault clears in the off-window
        wait_amp0(1'b0, 20, n);
        tick(20);
        uv_low = 2'b00;
        tick(50);
        chk("R7 off-window runs on", {ch0_state, amp_en[0]}, {2'b11, 1'b0});
        // R6: recovery in the next on-window
        wait_amp0(1'b1, 200, n);
        tick(ONC + 6);
        chk("R6 back to regulation", {ch0_state, amp_en[0]}, {2'b10, 1'b1});

        // R1: latency of a shutdown
        shut_n = 2'b10;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 before third edge", amp_en[0], 1);
        @(posedge clk);
        @(negedge clk);
        chk("R1 after third edge", {ch0_state, amp_en}, {2'b00, 2'b10});

        // R1: power-good removal
        pwr_good = 1'b0;
        tick(5);
        chk("R1 power-good low", {ch0_state, ch1_state, amp_en}, 6'b000000);

        // R9: reset while running
        pwr_good = 1'b1;
        shut_n = 2'b11;
        tick(100);
        rst = 1'b1;
        tick(3);
        chk("R9 reset mid-run", {ch0_state, ch1_state, amp_en}, 6'b000000);
        rst = 1'b0;
        tick(20);
        chk("R2 hold-off after reset", {ch0_state, ch1_state}, 4'b0101);
        tick(60);
        chk("R2 regulating", {ch0_state, ch1_state}, 4'b1010);

        // R8: pulse boundaries on channel 1
        uv_low = 2'b10;
        tick(GLT - 1);
        uv_low = 2'b00;
        tick(10);
        chk("R8 pulse one short", ch1_state, 2'b10);
        uv_low = 2'b10;
        tick(GLT);
        uv_low = 2'b00;
        tick(10);
        chk("R8 pulse full length", {ch1_state, amp_en[1]}, {2'b11, 1'b0});

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule